// File: doc/BRIEF.md
# Lane-Masked Synchronous SRAM Cycle Controller

This block holds a small word-wide synchronous memory and the logic that decides what each clock cycle does to it. The word has four lanes of nine bits each: eight data bits and one parity bit. On every rising edge the block looks at the chip select, two address-load strobes and three kinds of write control. A global write overrides the rest, a byte-write gate enables per-lane strobes, and a cycle that is neither is a read. From these inputs it picks one of four actions for the cycle: read, full-word write, lane-masked write, or power-down.

The address arrives ready-made from a separate burst address generator. A cycle with no load strobe carries on with whatever the last load set up. Read data is registered and shown one clock after its cycle. An output enable and a sleep input gate that data combinationally, with no clock involved. While the sleep input is high, the block ignores everything else and keeps its contents.

Top module: `lane_sram_ctrl`

## Requirements
- R1: After reset, dataOe is 0 and rdData is 0, and the block is powered down. Cycles without a load strobe do nothing until a load with ceN low occurs. All memory words read as zero.
- R2: A read cycle registers the word at addr. The word appears on rdData after the next rising edge, with dataOe high, while oeN and sleep are low.
- R3: When gwN is low in a write-capable cycle, all 36 bits are written from wrData, whatever bweN and laneWrN are.
- R4: When gwN is high and bweN is low, lane i (bits 9*i+8 down to 9*i, where bit 9*i+8 is that lane's parity bit) is written only if laneWrN[i] is low. Lanes whose strobe is high keep their contents.
- R5: When gwN and bweN are both high, or when no lane strobe is low, the cycle is a read.
- R6: A cycle loaded by adspN low with ceN low is always a read and leaves the memory unchanged, whatever the write inputs are.
- R7: A load by adscN low with ceN high, when adspN is not loading, powers the block down. From the next edge, outputs are disabled. Later cycles without a load neither read nor write, until a load with ceN low.
- R8: ceN is looked at only in cycles where adspN or adscN is low. A cycle with no strobe, after a load, reads or writes regardless of ceN.
- R9: adspN low with ceN high is ignored. If adscN is also high, the cycle behaves as a cycle with no load strobe.
- R10: While sleep is high, dataOe and rdData are 0 at once. Clock edges change neither the memory, the power-down state nor the held read word. The held read word shows again when sleep falls.
- R11: oeN high forces dataOe and rdData to 0 with no clock edge, and oeN low restores them.
- R12: A write cycle leaves dataOe at 0 after the following rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| sleep | input | 1 | Active-high standby; ignores other inputs and hides output |
| ceN | input | 1 | Active-low chip select, sampled on load cycles |
| adspN | input | 1 | Active-low load strobe, read-only side |
| adscN | input | 1 | Active-low load strobe, read/write/power-down side |
| gwN | input | 1 | Active-low full-word write |
| bweN | input | 1 | Active-low gate for the lane strobes |
| laneWrN | input | 4 | Active-low per-lane write strobes, bit i for lane i |
| oeN | input | 1 | Active-low output enable, combinational |
| addr | input | 4 | Word address from the burst generator |
| wrData | input | 36 | Write data, lane i at bits 9*i+8:9*i |
| rdData | output | 36 | Registered read word, zero when not enabled |
| dataOe | output | 1 | High when rdData is valid and driven |

## Verification
The bench builds the block with its defaults: 4 lanes of 9 bits and a 16-word depth. At this size every lane mask and the overlap of a write with a following read on the same word can be reached in a few dozen cycles. The narrow address lets the bench go back to the same word after lane-masked writes, power-down and sleep, so any lane disturbed in between becomes visible. It also reaches cycles in which both strobes are low and ceN is high, which separates the priority of the two load sides.

// File: rtl/lane_sram_pkg.sv
package lane_sram_pkg;
  localparam int MAX_LANES = 8;

  // strobes from the cycle decoder to the storage
  typedef struct packed {
    logic                 rdEn;
    logic                 wrEn;
    logic [MAX_LANES-1:0] laneWe;
  } strobe_t;
endpackage

// File: rtl/lane_sram_ctl.sv
module lane_sram_ctl
  import lane_sram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sleep,
  input  logic             ceN,
  input  logic             adspN,
  input  logic             adscN,
  input  logic             gwN,
  input  logic             bweN,
  input  logic [LANES-1:0] laneWrN,
  output strobe_t          strobes,
  output logic             rdValid
);
  logic pdQ;
  logic procLoad, ctrlLoad, pdReq, active;
  logic [LANES-1:0] mask;

  always_comb begin
    // R9: processor strobe only counts with chip select low
    procLoad = !adspN && !ceN;
    ctrlLoad = !adscN && !procLoad;
    pdReq    = ctrlLoad && ceN;               // R7
    // R8: ceN ignored on cycles with no load
    active   = procLoad || (ctrlLoad && !ceN) || (!procLoad && !ctrlLoad && !pdQ);
    if (!gwN)       mask = '1;                // R3
    else if (!bweN) mask = ~laneWrN;          // R4
    else            mask = '0;                // R5
    strobes        = '0;
    strobes.wrEn   = !sleep && active && !procLoad && (mask != '0); // R6
    strobes.rdEn   = !sleep && active && !strobes.wrEn;
    strobes.laneWe[LANES-1:0] = strobes.wrEn ? mask : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pdQ     <= 1'b1;                        // R1
      rdValid <= 1'b0;
    end else if (!sleep) begin                // R10
      if (pdReq)                         pdQ <= 1'b1;
      else if (procLoad || ctrlLoad)     pdQ <= 1'b0;
      rdValid <= strobes.rdEn;                // R12
    end
  end
endmodule

// File: rtl/lane_sram_dp.sv
module lane_sram_dp
  import lane_sram_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int LANE_BITS = 9,
  parameter int ADDR_W    = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobe_t                     strobes,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [LANES*LANE_BITS-1:0]  wrData,
  output logic [LANES*LANE_BITS-1:0]  rdWord
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int WORD  = LANES * LANE_BITS;

  logic [WORD-1:0] arrayOut;

  for (genvar l = 0; l < LANES; l++) begin : gLane
    logic [LANE_BITS-1:0] laneMem [DEPTH];
    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int i = 0; i < DEPTH; i++) laneMem[i] <= '0;
      end else if (strobes.laneWe[l]) begin   // R4
        laneMem[addr] <= wrData[l*LANE_BITS +: LANE_BITS];
      end
    end
    assign arrayOut[l*LANE_BITS +: LANE_BITS] = laneMem[addr];
  end

  always_ff @(posedge clk) begin
    if (!rstN)             rdWord <= '0;
    else if (strobes.rdEn) rdWord <= arrayOut;  // R2
  end
endmodule

// File: rtl/lane_sram_ctrl.sv
module lane_sram_ctrl
  import lane_sram_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int LANE_BITS = 9,
  parameter int ADDR_W    = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sleep,
  input  logic                       ceN,
  input  logic                       adspN,
  input  logic                       adscN,
  input  logic                       gwN,
  input  logic                       bweN,
  input  logic [LANES-1:0]           laneWrN,
  input  logic                       oeN,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [LANES*LANE_BITS-1:0] wrData,
  output logic [LANES*LANE_BITS-1:0] rdData,
  output logic                       dataOe
);
  strobe_t strobes;
  logic    rdValid;
  logic [LANES*LANE_BITS-1:0] rdWord;

  lane_sram_ctl #(.LANES(LANES)) uCtl (
    .clk, .rstN, .sleep, .ceN, .adspN, .adscN, .gwN, .bweN, .laneWrN,
    .strobes, .rdValid
  );

  lane_sram_dp #(.LANES(LANES), .LANE_BITS(LANE_BITS), .ADDR_W(ADDR_W)) uDp (
    .clk, .rstN, .strobes, .addr, .wrData, .rdWord
  );

  // R10 R11: combinational output gating
  assign dataOe = rdValid && !oeN && !sleep;
  assign rdData = dataOe ? rdWord : '0;
endmodule

// File: rtl/lane_sram_chk.sv
module lane_sram_chk #(
  parameter int WORD = 36
) (
  input logic            clk,
  input logic            rstN,
  input logic            sleep,
  input logic            ceN,
  input logic            adspN,
  input logic            adscN,
  input logic            gwN,
  input logic            oeN,
  input logic [WORD-1:0] rdData,
  input logic            dataOe
);
  AST_OE_GATE: assert property (@(posedge clk) disable iff (!rstN)
    oeN |-> (!dataOe && rdData == '0)); // R11

  AST_PD_DARK: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && !adscN && ceN) |=> !dataOe); // R7

  AST_WRITE_DARK: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && !adscN && adspN && !ceN && !gwN) |=> !dataOe); // R12

  AST_PROC_READ: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && !adspN && !ceN) |=> (dataOe == (!oeN && !sleep))); // R6

  AST_SLEEP_DARK: assert property (@(posedge clk) disable iff (!rstN)
    sleep |-> (!dataOe && rdData == '0)); // R10
endmodule

bind lane_sram_ctrl lane_sram_chk #(.WORD(LANES*LANE_BITS)) uChk (
  .clk, .rstN, .sleep, .ceN, .adspN, .adscN, .gwN, .oeN, .rdData, .dataOe
);

// File: tb/sim_lane_sram_ctrl.sv
`timescale 1ns/1ps
module sim_lane_sram_ctrl;
  logic clk = 0, rstN = 0, sleep = 0, ceN = 1, adspN = 1, adscN = 1;
  logic gwN = 1, bweN = 1, oeN = 0;
  logic [3:0]  laneWrN = 4'hF;
  logic [3:0]  addr = 0;
  logic [35:0] wrData = 0;
  logic [35:0] rdData;
  logic        dataOe;

  int compared = 0, mismatched = 0;
  bit done = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  lane_sram_ctrl u0 (.clk, .rstN, .sleep, .ceN, .adspN, .adscN, .gwN, .bweN,
                     .laneWrN, .oeN, .addr, .wrData, .rdData, .dataOe);

  // behavioural reference
  bit [35:0] mMem [16];
  bit        mPd, mVal, ldP, ldC, go;
  bit [35:0] mRd, bitMask;
  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mMem[i]) mMem[i] = 0;
      mPd = 1; mVal = 0; mRd = 0;
    end else if (!sleep) begin
      ldP = !adspN && !ceN;
      ldC = !adscN && !ldP;
      if (ldC && ceN) begin
        mPd = 1; mVal = 0;
      end else begin
        go = ldP || ldC || !mPd;
        if (ldP || ldC) mPd = 0;
        bitMask = 0;
        if (!gwN) bitMask = '1;
        else if (!bweN)
          for (int k = 0; k < 4; k++) if (!laneWrN[k]) bitMask[k*9 +: 9] = 9'h1FF;
        if (!go) mVal = 0;
        else if (!ldP && bitMask != 0) begin
          mMem[addr] = (mMem[addr] & ~bitMask) | (wrData & bitMask);
          mVal = 0;
        end else begin
          mRd = mMem[addr]; mVal = 1;
        end
      end
    end
  end

  task automatic compare();
    bit        eOe = mVal && !oeN && !sleep;
    bit [35:0] eD  = eOe ? mRd : 36'h0;
    compared++;
    if (dataOe !== eOe || rdData !== eD) begin
      mismatched++;
      $display("FAIL %s: rdData=%h dataOe=%b expected rdData=%h dataOe=%b",
               tag, rdData, dataOe, eD, eOe);
    end
  endtask

  task automatic cyc(input string t, input bit p, input bit c, input bit ce,
                     input bit g, input bit b, input logic [3:0] lw,
                     input logic [3:0] a, input logic [35:0] d);
    @(negedge clk);
    tag = t; adspN = p; adscN = c; ceN = ce; gwN = g; bweN = b;
    laneWrN = lw; addr = a; wrData = d;
    #1 compare();
  endtask

  // one idle-input cycle that only observes
  task automatic look(input string t);
    cyc(t, 1, 1, 1, 1, 1, 4'hF, addr, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    #1 tag = "R1"; compare();
    // R1: powered down, a no-strobe write attempt is dropped
    cyc("R1", 1, 1, 0, 0, 1, 4'hF, 4'd2, 36'hFFFFFFFFF);
    cyc("R1", 1, 0, 0, 1, 1, 4'hF, 4'd2, 0);
    look("R1");
    // R3: global write overrides lane controls
    cyc("R3", 1, 0, 0, 0, 0, 4'hF, 4'd1, 36'h123456789);
    look("R12");
    // R6: processor load with write inputs active is a read
    cyc("R6", 0, 1, 0, 0, 0, 4'h0, 4'd1, 36'hABCDEF012);
    look("R2");
    // R4: lanes 0 and 2 written
    cyc("R4", 1, 0, 0, 1, 0, 4'b1010, 4'd1, 36'hFFFFFFFFF);
    cyc("R5", 1, 1, 1, 1, 1, 4'b0000, 4'd1, 0);
    look("R4");
    // R4: parity bit of lane 3 only via lane 3
    cyc("R4", 1, 1, 0, 1, 0, 4'b0111, 4'd1, 36'h800000000);
    cyc("R5", 1, 0, 0, 1, 0, 4'b1111, 4'd1, 0);
    look("R4");
    // R11: asynchronous output enable
    @(negedge clk); #2 oeN = 1; #1 tag = "R11"; compare();
    #1 oeN = 0; #1 compare();
    // R7: power-down, later writes/reads dropped
    cyc("R7", 1, 0, 1, 1, 1, 4'hF, 4'd1, 0);
    cyc("R7", 1, 1, 0, 0, 1, 4'hF, 4'd1, 36'h0);
    look("R7");
    cyc("R7", 0, 1, 0, 1, 1, 4'hF, 4'd1, 0);
    look("R7");
    // R9: processor strobe with ceN high ignored; continuation writes
    cyc("R9", 0, 1, 1, 0, 1, 4'hF, 4'd5, 36'h0A5A5A5A5);
    cyc("R9", 1, 1, 1, 1, 1, 4'hF, 4'd5, 0);
    look("R9");
    // R9 with both strobes low and ceN high: power-down
    cyc("R9", 0, 0, 1, 1, 1, 4'hF, 4'd5, 0);
    look("R9");
    // R8: ceN high on a no-strobe cycle still works
    cyc("R8", 1, 0, 0, 1, 1, 4'hF, 4'd6, 0);
    cyc("R8", 1, 1, 1, 0, 1, 4'hF, 4'd6, 36'h555555555);
    cyc("R8", 1, 1, 1, 1, 1, 4'hF, 4'd6, 0);
    look("R8");
    // R10: sleep ignores everything and hides output
    @(negedge clk); sleep = 1; #1 tag = "R10"; compare();
    cyc("R10", 1, 0, 0, 0, 1, 4'hF, 4'd6, 36'h0);
    cyc("R10", 1, 0, 1, 1, 1, 4'hF, 4'd6, 0);
    @(negedge clk); sleep = 0; #1 tag = "R10"; compare();
    cyc("R10", 1, 1, 1, 1, 1, 4'hF, 4'd6, 0);
    look("R10");
    // R2: back-to-back reads across words
    for (int w = 0; w < 8; w++) cyc("R2", 1, 0, 0, 1, 1, 4'hF, 4'(w), 0);
    look("R2");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule